// File: doc/BRIEF.md
# Inclusive Last-Level Cache Slice Directory

This block is the tag and presence directory of one slice of a shared, inclusive last-level cache. Requesters hash physical addresses to pick a slice, so each slice sees a fixed part of the address space. Every request carries an address, the requesting core and a read or ownership type. The slice answers one cycle later with hit, miss or retry. On a hit it also emits a targeted snoop, sent only to the cores whose presence bit is set for that line. A miss becomes a memory request, and an entry in a small table of outstanding misses keeps a second request to the same line out until the fill arrives.

A fill installs the returned line. It picks an invalid way first, then a tree pseudo-LRU victim among the 16 ways. When the victim has holders, a back-invalidation goes to exactly those cores in the cycle after the fill, so the cores never keep a line that the slice has dropped. Each line keeps a MESI state (I=0, S=1, E=2, M=3) and a presence vector as wide as the core count. The data array, the ring transport and memory itself are outside the block.

Top module: `llc_incl_slice`

## Requirements
- R1: Address bits [5:0] (byte offset) and [7:6] (slice field) take no part in lookup. The set index is bits [11:8] and the tag is bits [31:12]. Two addresses that differ only in the ignored bits select the same line.
- R2: A request that misses, whose line has no outstanding miss, while a tracker entry is free, gets resp_code 2 (miss) in the next cycle. In that same cycle mem_req_valid is high and mem_req_addr = {req_addr[31:8], slice id 2'b01, 6'b0}.
- R3: A read hit (resp_code 1) sends a probe snoop (snp_kind 1) to the holders other than the requester, but only when the line is E or M. The requester's presence bit is then set. The line becomes S if any other core holds it and otherwise keeps its state. resp_state reports the new state.
- R4: An ownership hit sends an invalidate snoop (snp_kind 2) to every other holder, if there are any. The requester is left as sole holder and the line becomes M.
- R5: A fill sets only the filling core's presence bit. The state is E for a read fill (fill_own=0) and M for an ownership fill.
- R6: A fill uses the lowest-numbered invalid way of its set. If no way is invalid, it uses the tree pseudo-LRU victim. The tree has 15 node bits; node n has children 2n and 2n+1, and way w is leaf 16+w. At each node, a bit value of 0 selects the lower child. Every hit and every fill points each node on the touched way's path away from that way.
- R7: When a fill replaces a valid line with holders, snp_kind 3 (back-invalidate) is raised in the next cycle. Its mask is the victim's presence vector and its address is the victim's line address.
- R8: A missing request whose line already has an outstanding miss, or that arrives while all 4 tracker entries are busy, gets resp_code 3 (retry). It raises no memory request.
- R9: A fill releases the tracker entry for its line, and later requests to that line hit.
- R10: A request presented in the same cycle as a fill gets retry and changes no state.
- R11: After reset no line is valid and resp_valid, snp_valid and mem_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request physical address |
| req_core | input | 2 | Requesting core |
| req_own | input | 1 | 1 = ownership request, 0 = read |
| fill_valid | input | 1 | Fill present |
| fill_addr | input | 32 | Fill line address |
| fill_core | input | 2 | Core that receives the filled line |
| fill_own | input | 1 | Fill grants ownership |
| resp_valid | output | 1 | Response present |
| resp_code | output | 2 | 1 hit, 2 miss, 3 retry |
| resp_state | output | 2 | Line state after the access (I on miss/retry) |
| snp_valid | output | 1 | Snoop present |
| snp_kind | output | 2 | 1 probe, 2 invalidate, 3 back-invalidate |
| snp_mask | output | 4 | Cores to snoop |
| snp_addr | output | 32 | Snooped line address |
| mem_req_valid | output | 1 | Memory request for a miss |
| mem_req_addr | output | 32 | Line address sent to memory |

## Verification
The main traffic is a long mixed stream over two sets and 24 tags, which overflows the 16 ways. It interleaves reads and ownership requests from all four cores, fills in random order and fill-request collisions, so probe, invalidate and back-invalidate masks are checked under many holder patterns. A directed fill sweep of one set separates invalid-first allocation from tree replacement: the addresses of the back-invalidated victims show the order directly. Directed runs on the miss tracker tell a retry caused by a duplicate line apart from one caused by a full table. Lookups that vary only the offset and slice bits show that those bits take no part in lookup.

// File: rtl/llc_slice_pkg.sv
package llc_slice_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_HIT = 2'd1, RSP_MISS = 2'd2, RSP_RETRY = 2'd3} rsp_e;
  typedef enum logic [1:0] {SNP_NONE = 2'd0, SNP_PROBE = 2'd1, SNP_INV = 2'd2, SNP_BINV = 2'd3} snp_e;

  // Single-owner states may hold a dirty or private copy elsewhere.
  function automatic logic single_owner(input mesi_e s);
    return (s == ST_E) || (s == ST_M);
  endfunction
endpackage

// File: rtl/llc_plru_tree.sv
module llc_plru_tree #(
  parameter int WAYS = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-2:0]  tree_in,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way,
  output logic [WAYS-2:0]  tree_out
);
  // Node n (1-based) is bit n-1; children are 2n and 2n+1; way w is leaf WAYS+w.
  function automatic logic [WAY_W-1:0] pick(input logic [WAYS-2:0] t);
    int unsigned n;
    n = 1;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(t[n-1]);
    return WAY_W'(n - WAYS);
  endfunction

  function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t, input logic [WAY_W-1:0] w);
    logic [WAYS-2:0] r;
    int unsigned n;
    r = t;
    n = WAYS + int'(w);
    for (int l = 0; l < WAY_W; l++) begin
      r[(n >> 1) - 1] = ~n[0];
      n = n >> 1;
    end
    return r;
  endfunction

  assign victim_way = pick(tree_in);
  assign tree_out   = touch(tree_in, touch_way);

  always_comb begin
    a_touch_not_victim_r6: assert (pick(tree_out) != touch_way);
  end
endmodule

// File: rtl/llc_miss_track.sv
module llc_miss_track #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 24,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] q_line,
  output logic              q_hit,
  output logic              q_full,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic              rel_en,
  input  logic [LINE_W-1:0] rel_line
);
  logic [ENTRIES-1:0] busy_q;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [ENTRIES-1:0] q_match, r_match;
  logic [IDX_W-1:0]   free_idx;

  always_comb begin
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      q_match[e] = busy_q[e] && (line_q[e] == q_line);
      r_match[e] = busy_q[e] && (line_q[e] == rel_line);
      if (!busy_q[e]) free_idx = IDX_W'(e);
    end
  end

  assign q_hit  = |q_match;
  assign q_full = &busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++)
        if (rel_en && r_match[e]) busy_q[e] <= 1'b0;
      if (alloc_en && !q_full) busy_q[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en && !q_full) line_q[free_idx] <= alloc_line;
  end

  p_alloc_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !q_hit);
  p_alloc_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !q_full);
  p_release_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !alloc_en) |=> !(q_hit && (q_line == $past(rel_line))));
endmodule

// File: rtl/llc_incl_slice.sv
module llc_incl_slice
  import llc_slice_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NCORES   = 4,
  parameter int WAYS     = 16,
  parameter int SET_W    = 4,
  parameter int SLICE_W  = 2,
  parameter int SLICE_ID = 1,
  parameter int MSHR_N   = 4,
  localparam int CORE_W  = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_own,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [CORE_W-1:0] fill_core,
  input  logic              fill_own,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic [1:0]        resp_state,
  output logic              snp_valid,
  output logic [1:0]        snp_kind,
  output logic [NCORES-1:0] snp_mask,
  output logic [ADDR_W-1:0] snp_addr,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr
);
  localparam int OFF_W  = 6;
  localparam int LOW_W  = OFF_W + SLICE_W;
  localparam int TAG_W  = ADDR_W - LOW_W - SET_W;
  localparam int LINE_W = TAG_W + SET_W;
  localparam int SETS   = 1 << SET_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [SLICE_W-1:0] SLICE_BITS = SLICE_W'(SLICE_ID);

  // ---------------- address arithmetic ----------------
  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LOW_W];
  endfunction
  function automatic logic [ADDR_W-1:0] line_addr(input logic [LINE_W-1:0] l);
    return {l, SLICE_BITS, {OFF_W{1'b0}}};
  endfunction
  function automatic logic [WAY_W-1:0] lowest_set(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction
  function automatic logic [NCORES-1:0] core_bit(input logic [CORE_W-1:0] c);
    return NCORES'(1) << c;
  endfunction

  // ---------------- directory storage ----------------
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [NCORES-1:0] cv_q   [SETS][WAYS];
  mesi_e             st_q   [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-2:0]   plru_q [SETS];

  logic unused_low_bits;
  assign unused_low_bits = ^{req_addr[LOW_W-1:0], fill_addr[LOW_W-1:0]};

  // ---------------- request lookup ----------------
  logic [LINE_W-1:0] r_line;
  logic [SET_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  logic [WAYS-1:0]   r_hit_vec;
  logic              r_hit;
  logic [WAY_W-1:0]  r_way;

  assign r_line = line_of(req_addr);
  assign r_set  = r_line[SET_W-1:0];
  assign r_tag  = r_line[LINE_W-1:SET_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      r_hit_vec[w] = vld_q[r_set][w] && (tag_q[r_set][w] == r_tag);
  end
  assign r_hit = |r_hit_vec;
  assign r_way = lowest_set(r_hit_vec);

  // ---------------- fill allocation ----------------
  logic [LINE_W-1:0] f_line;
  logic [SET_W-1:0]  f_set;
  logic [TAG_W-1:0]  f_tag;
  logic              f_has_free;
  logic [WAY_W-1:0]  f_free_way, f_plru_way, f_way;
  logic              v_vld;
  logic [NCORES-1:0] v_cv;
  logic [TAG_W-1:0]  v_tag;

  assign f_line     = line_of(fill_addr);
  assign f_set      = f_line[SET_W-1:0];
  assign f_tag      = f_line[LINE_W-1:SET_W];
  assign f_has_free = ~&vld_q[f_set];
  assign f_free_way = lowest_set(~vld_q[f_set]);
  assign f_way      = f_has_free ? f_free_way : f_plru_way;
  assign v_vld      = vld_q[f_set][f_way];
  assign v_cv       = cv_q[f_set][f_way];
  assign v_tag      = tag_q[f_set][f_way];

  // One replacement tree port, shared: fills take priority over requests.
  logic [WAYS-2:0]  plru_in, plru_next;
  logic [WAY_W-1:0] plru_touch;
  assign plru_in    = fill_valid ? plru_q[f_set] : plru_q[r_set];
  assign plru_touch = fill_valid ? f_way : r_way;

  llc_plru_tree #(.WAYS(WAYS)) plru_i (
    .tree_in    (plru_in),
    .touch_way  (plru_touch),
    .victim_way (f_plru_way),
    .tree_out   (plru_next)
  );

  // ---------------- outstanding misses ----------------
  logic mt_hit, mt_full;

  // ---------------- named events ----------------
  logic ev_req, ev_collide, ev_rd_hit, ev_own_hit, ev_miss, ev_alloc;
  logic ev_backinv, ev_probe, ev_inv;
  assign ev_req     = req_valid && !fill_valid;
  assign ev_collide = req_valid && fill_valid;
  assign ev_rd_hit  = ev_req && r_hit && !req_own;
  assign ev_own_hit = ev_req && r_hit && req_own;
  assign ev_miss    = ev_req && !r_hit;
  assign ev_alloc   = ev_miss && !mt_hit && !mt_full;
  assign ev_backinv = fill_valid && v_vld && (v_cv != '0);

  llc_miss_track #(.ENTRIES(MSHR_N), .LINE_W(LINE_W)) track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_line     (r_line),
    .q_hit      (mt_hit),
    .q_full     (mt_full),
    .alloc_en   (ev_alloc),
    .alloc_line (r_line),
    .rel_en     (fill_valid),
    .rel_line   (f_line)
  );

  // ---------------- hit-path presence/state update ----------------
  logic [NCORES-1:0] h_cv, rq_bit, others, hit_snp_mask, new_cv;
  mesi_e             h_st, new_st;

  assign h_cv   = cv_q[r_set][r_way];
  assign h_st   = st_q[r_set][r_way];
  assign rq_bit = core_bit(req_core);
  assign others = h_cv & ~rq_bit;

  always_comb begin
    if (req_own) begin
      hit_snp_mask = others;
      new_cv       = rq_bit;
      new_st       = ST_M;
    end else begin
      hit_snp_mask = single_owner(h_st) ? others : '0;
      new_cv       = h_cv | rq_bit;
      new_st       = (others != '0) ? ST_S : h_st;
    end
  end
  assign ev_probe = ev_rd_hit && (hit_snp_mask != '0);
  assign ev_inv   = ev_own_hit && (hit_snp_mask != '0);

  // ---------------- state with reset ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else if (fill_valid) begin
      vld_q[f_set][f_way] <= 1'b1;
      plru_q[f_set]       <= plru_next;
    end else if (ev_rd_hit || ev_own_hit) begin
      plru_q[r_set] <= plru_next;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[f_set][f_way] <= f_tag;
      cv_q[f_set][f_way]  <= core_bit(fill_core);
      st_q[f_set][f_way]  <= fill_own ? ST_M : ST_E;
    end else if (ev_rd_hit || ev_own_hit) begin
      cv_q[r_set][r_way] <= new_cv;
      st_q[r_set][r_way] <= new_st;
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_code     <= RSP_NONE;
      resp_state    <= ST_I;
      snp_valid     <= 1'b0;
      snp_kind      <= SNP_NONE;
      snp_mask      <= '0;
      snp_addr      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      resp_valid    <= req_valid;
      resp_code     <= RSP_NONE;
      resp_state    <= ST_I;
      snp_valid     <= 1'b0;
      snp_kind      <= SNP_NONE;
      snp_mask      <= '0;
      snp_addr      <= '0;
      mem_req_valid <= ev_alloc;
      mem_req_addr  <= ev_alloc ? line_addr(r_line) : '0;
      if (ev_collide)                resp_code <= RSP_RETRY;
      else if (ev_rd_hit || ev_own_hit) begin
        resp_code  <= RSP_HIT;
        resp_state <= new_st;
      end
      else if (ev_alloc)             resp_code <= RSP_MISS;
      else if (ev_miss)              resp_code <= RSP_RETRY;
      if (ev_backinv) begin
        snp_valid <= 1'b1;
        snp_kind  <= SNP_BINV;
        snp_mask  <= v_cv;
        snp_addr  <= line_addr({v_tag, f_set});
      end else if (ev_probe || ev_inv) begin
        snp_valid <= 1'b1;
        snp_kind  <= ev_inv ? SNP_INV : SNP_PROBE;
        snp_mask  <= hit_snp_mask;
        snp_addr  <= line_addr(r_line);
      end
    end
  end

  // ---------------- assertions ----------------
  p_memreq_with_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (resp_valid && (resp_code == RSP_MISS)));
  p_snoop_skips_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_kind != SNP_BINV)) |-> ((snp_mask & core_bit($past(req_core))) == '0));
  p_own_hit_is_m_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_code == RSP_HIT) && $past(req_own)) |-> (resp_state == ST_M));
  p_snoop_has_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (snp_mask != '0));
  p_collision_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid) && $past(req_valid)) |-> (resp_code == RSP_RETRY));
endmodule

// File: tb/llc_incl_slice_tb.sv
`timescale 1ns/1ps
module llc_incl_slice_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_own = 0, fill_valid = 0, fill_own = 0;
  logic [31:0] req_addr = '0, fill_addr = '0;
  logic [1:0]  req_core = '0, fill_core = '0;
  logic        resp_valid, snp_valid, mem_req_valid;
  logic [1:0]  resp_code, resp_state, snp_kind;
  logic [3:0]  snp_mask;
  logic [31:0] snp_addr, mem_req_addr;

  llc_incl_slice dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_core(req_core), .req_own(req_own),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_core(fill_core), .fill_own(fill_own),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_state(resp_state),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_mask(snp_mask), .snp_addr(snp_addr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench-side model of the directory
  bit          m_vld [16][16];
  logic [19:0] m_tag [16][16];
  logic [3:0]  m_cv  [16][16];
  int          m_st  [16][16];
  logic [14:0] m_pl  [16];
  logic [23:0] p_line [4];
  int          p_core [4];
  bit          p_own  [4];
  int          npend = 0;

  function automatic logic [31:0] mk(input int tag, input int set, input int slc, input int off);
    return {20'(tag), 4'(set), 2'(slc), 6'(off)};
  endfunction

  // 0-based heap walk: child of k is 2k+1+bit, leaves start at 15
  function automatic int b_pick(input logic [14:0] t);
    int k = 0;
    while (k < 15) k = 2 * k + 1 + int'(t[k]);
    return k - 15;
  endfunction

  function automatic logic [14:0] b_touch(input logic [14:0] t, input int way);
    logic [14:0] r = t;
    int k = 15 + way;
    while (k > 0) begin
      int p = (k - 1) / 2;
      r[p] = (k == 2 * p + 1);
      k = p;
    end
    return r;
  endfunction

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input string lab, input bit dq, input logic [31:0] qa, input int qc, input bit qo,
                      input bit df, input logic [31:0] fa, input int fc, input bit fo);
    int e_code = 0, e_st = 0, e_sk = 0;
    bit e_sv = 0, e_mv = 0;
    logic [3:0]  e_sm = '0;
    logic [31:0] e_sa = '0, e_ma = '0;
    string rq = lab;
    if (df) begin
      int fs = int'(fa[11:8]);
      int v = -1;
      for (int w = 15; w >= 0; w--) if (!m_vld[fs][w]) v = w;
      if (v < 0) v = b_pick(m_pl[fs]);
      rq = {lab, " R7"};
      if (m_vld[fs][v] && m_cv[fs][v] != 0) begin
        e_sv = 1; e_sk = 3; e_sm = m_cv[fs][v];
        e_sa = {m_tag[fs][v], 4'(fs), 2'b01, 6'h0};
      end
      m_vld[fs][v] = 1; m_tag[fs][v] = fa[31:12];
      m_cv[fs][v] = 4'b1 << fc; m_st[fs][v] = fo ? 3 : 2;
      m_pl[fs] = b_touch(m_pl[fs], v);
      for (int j = 0; j < npend; j++)
        if (p_line[j] == fa[31:8]) begin
          p_line[j] = p_line[npend-1]; p_core[j] = p_core[npend-1]; p_own[j] = p_own[npend-1];
          npend--;
          break;
        end
      if (dq) begin e_code = 3; rq = {lab, " R10"}; end
    end else if (dq) begin
      int s = int'(qa[11:8]);
      int h = -1;
      logic [3:0] rb = 4'b1 << qc;
      for (int w = 0; w < 16; w++) if (m_vld[s][w] && m_tag[s][w] == qa[31:12]) h = w;
      if (h >= 0) begin
        logic [3:0] cv = m_cv[s][h];
        logic [3:0] pm;
        int st = m_st[s][h];
        if (qo) begin
          pm = cv & ~rb; m_cv[s][h] = rb; m_st[s][h] = 3; e_sk = 2; rq = {lab, " R4"};
        end else begin
          pm = (st >= 2) ? (cv & ~rb) : 4'b0;
          m_cv[s][h] = cv | rb;
          if ((cv & ~rb) != 0) m_st[s][h] = 1;
          e_sk = 1; rq = {lab, " R3"};
        end
        e_code = 1; e_st = m_st[s][h];
        if (pm != 0) begin e_sv = 1; e_sm = pm; e_sa = {qa[31:8], 2'b01, 6'h0}; end
        m_pl[s] = b_touch(m_pl[s], h);
      end else begin
        bit dup = 0;
        for (int j = 0; j < npend; j++) if (p_line[j] == qa[31:8]) dup = 1;
        if (dup || npend == 4) begin
          e_code = 3; rq = {lab, " R8"};
        end else begin
          e_code = 2; e_mv = 1; e_ma = {qa[31:8], 2'b01, 6'h0}; rq = {lab, " R2"};
          p_line[npend] = qa[31:8]; p_core[npend] = qc; p_own[npend] = qo; npend++;
        end
      end
    end
    @(negedge clk);
    req_valid = dq; req_addr = qa; req_core = 2'(qc); req_own = qo;
    fill_valid = df; fill_addr = fa; fill_core = 2'(fc); fill_own = fo;
    @(negedge clk);
    chk(rq, "resp_valid", resp_valid, dq);
    if (dq) begin
      chk(rq, "resp_code", resp_code, e_code);
      chk(rq, "resp_state", resp_state, e_st);
    end
    chk(rq, "snp_valid", snp_valid, e_sv);
    if (e_sv) begin
      chk(rq, "snp_kind", snp_kind, e_sk);
      chk(rq, "snp_mask", snp_mask, e_sm);
      chk(rq, "snp_addr", snp_addr, e_sa);
    end
    chk(rq, "mem_req_valid", mem_req_valid, e_mv);
    if (e_mv) chk(rq, "mem_req_addr", mem_req_addr, e_ma);
    req_valid = 0; fill_valid = 0;
  endtask

  task automatic rd(input string lab, input logic [31:0] a, input int c, input bit o);
    step(lab, 1, a, c, o, 0, '0, 0, 0);
  endtask
  task automatic fl(input string lab, input logic [31:0] a, input int c, input bit o);
    step(lab, 0, '0, 0, 0, 1, a, c, o);
  endtask
  task automatic fill_pending(input string lab, input int j, input bit with_req, input logic [31:0] qa, input int qc);
    step(lab, with_req, qa, qc, 0, 1, {p_line[j], 2'b01, 6'h0}, p_core[j], p_own[j]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      m_pl[s] = '0;
      for (int w = 0; w < 16; w++) begin m_vld[s][w] = 0; m_cv[s][w] = '0; m_st[s][w] = 0; m_tag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11", "resp_valid", resp_valid, 0);
    chk("R11", "snp_valid", snp_valid, 0);
    chk("R11", "mem_req_valid", mem_req_valid, 0);
    rd("R11", mk(5, 0, 1, 0), 0, 0);
    fill_pending("R11", 0, 0, '0, 0);

    // R6: fill one set past its capacity, victims show the replacement order
    for (int i = 0; i < 20; i++) begin
      rd("R6", mk(i, 3, 1, 0), i % 4, 0);
      fill_pending("R6", 0, 0, '0, 0);
    end
    rd("R6", mk(5, 3, 1, 0), 1, 0);
    rd("R6", mk(9, 3, 1, 0), 2, 1);
    for (int i = 20; i < 26; i++) begin
      rd("R6", mk(i, 3, 1, 0), i % 4, 1);
      fill_pending("R6", 0, 0, '0, 0);
    end

    // R1: offset and slice field do not take part in lookup
    rd("R1", mk(40, 6, 1, 0), 2, 0);
    fill_pending("R1", 0, 0, '0, 0);
    rd("R1", mk(40, 6, 3, 37), 2, 0);
    rd("R1", mk(40, 6, 0, 63), 2, 0);

    // R5 then R3/R4 on the same line
    rd("R5", mk(41, 6, 1, 0), 3, 1);
    fill_pending("R5", 0, 0, '0, 0);
    rd("R5", mk(41, 6, 0, 9), 3, 0);
    rd("R3", mk(41, 6, 1, 0), 0, 0);
    rd("R3", mk(41, 6, 1, 0), 1, 0);
    rd("R4", mk(41, 6, 1, 0), 0, 1);

    // R8: duplicate line and full tracker
    rd("R8", mk(50, 7, 1, 0), 0, 0);
    rd("R8", mk(50, 7, 2, 4), 1, 0);
    rd("R8", mk(51, 7, 1, 0), 1, 0);
    rd("R8", mk(52, 7, 1, 0), 2, 1);
    rd("R8", mk(53, 7, 1, 0), 3, 0);
    rd("R8", mk(54, 7, 1, 0), 3, 0);
    // R9: fills release entries, lines then hit
    while (npend > 0) fill_pending("R9", 0, 0, '0, 0);
    rd("R9", mk(52, 7, 1, 0), 0, 0);
    rd("R9", mk(54, 7, 1, 0), 3, 0);

    // R10: collision with a fill
    rd("R10", mk(61, 8, 1, 0), 1, 0);
    fill_pending("R10", 0, 1, mk(60, 8, 1, 0), 2);
    rd("R10", mk(60, 8, 1, 0), 2, 0);
    fill_pending("R10", 0, 0, '0, 0);

    // mixed random traffic over two sets and 24 tags
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      logic [31:0] a = mk($urandom % 24, $urandom % 2, $urandom % 4, $urandom % 64);
      int c = $urandom % 4;
      if (npend > 0 && r < 35) fill_pending("mix", $urandom % npend, 0, '0, 0);
      else if (npend > 0 && r < 40) fill_pending("mix", $urandom % npend, 1, a, c);
      else rd("mix", a, c, (r % 3) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule